// File: doc/BRIEF.md
# Burst Write Target with Byte-Strobed Word Array

This block is the write side of a memory-mapped target on an AXI4 bus. It takes one burst request at a time on the write address channel, accepts the data beats of that burst on the write data channel, and writes each beat into a small internal word array. Byte lanes are written only where the beat's strobe bit is set. Once the beat marked as last has been taken, the block returns a single write response that carries the request's ID.

The address of each beat follows the burst type of the request: fixed (every beat at the start address), incrementing (step of the beat size, aligned after the first beat) or wrapping (incrementing inside an aligned window of beats times beat size). A request the block cannot honour, or a burst that runs outside the array or ends on the wrong beat, completes with a slave-error response. A combinational read port gives the owning subsystem a view of the stored words.

Top module: `axi_burst_write_target`

## Requirements
- R1: A channel transfer happens only on a rising edge where its valid and ready are both high; `awReady` is high whenever no burst is in progress, and low from the edge that accepts an address until the edge that completes its response.
- R2: For each accepted beat, byte lane k of the addressed word (bits 8k+7..8k) takes `wData` lane k exactly when `wStrb[k]` is 1; lanes with strobe 0 keep their old value.
- R3: Incrementing burst (`awBurst` = 2'b01): beat 0 uses the start byte address; each later beat uses the previous address rounded down to the beat size plus the beat size (1 << `awSize` bytes). The word written is byte address >> log2(DATA_W/8).
- R4: Fixed burst (`awBurst` = 2'b00): every beat writes the word at the start address.
- R5: Wrapping burst (`awBurst` = 2'b10): addresses advance by the beat size inside the aligned window of (`awLen`+1) << `awSize` bytes and wrap to the window's base; only 2, 4, 8 or 16 beats (`awLen` 1, 3, 7, 15) are accepted, any other length gives SLVERR and writes nothing.
- R6: Exactly one response is given per burst: `bValid` rises in the cycle after the edge that accepts the beat with `wLast`=1, and stays high with stable `bId` and `bResp` until the edge where `bReady` is high.
- R7: `bId` equals the `awId` captured with the burst's address.
- R8: A beat whose word index is at or above DEPTH is not written and makes the burst's response SLVERR (2'b10); in-range beats of the same burst are still written. Otherwise the response is OKAY (2'b00).
- R9: The burst ends on the beat carrying `wLast`; if that beat's index (counting from 0) differs from `awLen`, the response is SLVERR, and the block then waits for a new address.
- R10: A request with `awSize` larger than log2(DATA_W/8) or with `awBurst` = 2'b11 writes no beats and responds SLVERR.
- R11: Reset is active-low and synchronous: while `rstN` is low at an edge the array is cleared to zero and the block returns to idle, with `awReady`=1, `wReady`=0 and `bValid`=0 after it.
- R12: `wReady` is high only between the acceptance of an address and the acceptance of the beat carrying `wLast`; it is low while idle and while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| awId | input | ID_W | Request ID |
| awAddr | input | ADDR_W | Start byte address |
| awLen | input | 8 | Beats minus one |
| awSize | input | 3 | log2 of bytes per beat |
| awBurst | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping |
| awValid | input | 1 | Address valid |
| awReady | output | 1 | Address ready |
| wData | input | DATA_W | Beat data |
| wStrb | input | DATA_W/8 | Byte-lane write enables |
| wLast | input | 1 | Final beat marker |
| wValid | input | 1 | Data valid |
| wReady | output | 1 | Data ready |
| bId | output | ID_W | Response ID |
| bResp | output | 2 | Response code: 00 OKAY, 10 SLVERR |
| bValid | output | 1 | Response valid |
| bReady | input | 1 | Response ready |
| peekIdx | input | $clog2(DEPTH) | Word index for the array read port |
| peekData | output | DATA_W | Word at `peekIdx` |

## Verification
The bench goes after wrapping bursts that start mid-window, where a design that ignored the window would run past it and overwrite the next words; a start address that is not aligned in an incrementing burst, where a missing round-down would leave every later beat off by the misalignment; and a burst that straddles the top of the array, where a design that aliased the index would corrupt low words or report OKAY. It sends `wLast` one beat early and one beat late, which a design counting beats instead of watching `wLast` would turn into a hung data phase or a lost response. It also holds `bReady` low for several cycles to catch a response that drops or changes, and uses illegal sizes, burst code 2'b11 and a three-beat wrap, where a lax design would write memory.

// File: rtl/wbt_pkg.sv
`timescale 1ns/1ps
package wbt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_RESP} wbtState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // address handshake this edge
    logic beat;      // data handshake this edge
  } wbtCtl_s;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] BURST_WRAP  = 2'b10;
endpackage

// File: rtl/wbt_ctrl.sv
`timescale 1ns/1ps
module wbt_ctrl
  import wbt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    awValid,
  input  logic    wValid,
  input  logic    wLast,
  input  logic    bReady,
  output logic    awReady,
  output logic    wReady,
  output logic    bValid,
  output wbtCtl_s ctl
);
  wbtState_e state, stateNext;

  assign awReady     = (state == ST_IDLE);
  assign wReady      = (state == ST_DATA);
  assign bValid      = (state == ST_RESP);
  assign ctl.capture = awValid && awReady;
  assign ctl.beat    = wValid && wReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ctl.capture)         stateNext = ST_DATA;
      ST_DATA: if (ctl.beat && wLast)   stateNext = ST_RESP;
      ST_RESP: if (bReady)              stateNext = ST_IDLE;
      default:                          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R1: address channel closes after acceptance
  assert_aw_closed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady) |=> !awReady);

  // R6: a response only follows the final accepted beat
  assert_resp_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bValid) |-> $past(wValid && wReady && wLast));

  // R12: after a completed response the block is idle, not taking data
  assert_idle_after_resp_R12: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && bReady) |=> (awReady && !wReady && !bValid));
endmodule

// File: rtl/wbt_datapath.sv
`timescale 1ns/1ps
module wbt_datapath
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int LANES = DATA_W / 8,
  localparam int BYTE_SHIFT = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbtCtl_s           ctl,
  input  logic [ID_W-1:0]   awId,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [7:0]        awLen,
  input  logic [2:0]        awSize,
  input  logic [1:0]        awBurst,
  input  logic [DATA_W-1:0] wData,
  input  logic [LANES-1:0]  wStrb,
  input  logic              wLast,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [ID_W-1:0]   bId,
  output logic [1:0]        bResp,
  output logic [DATA_W-1:0] peekData
);
  logic [DATA_W-1:0] mem [DEPTH];

  logic [ID_W-1:0]   idReg;
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        lenReg;
  logic [2:0]        sizeReg;
  logic [1:0]        burstReg;
  logic [8:0]        beatCnt;
  logic              reqBad, errFlag;

  // Request legality, judged when the address arrives
  logic reqBadIn;
  assign reqBadIn = (awSize > 3'(BYTE_SHIFT)) || (awBurst == 2'b11) ||
                    ((awBurst == BURST_WRAP) && !(awLen inside {8'd1, 8'd3, 8'd7, 8'd15}));

  // Next beat address
  logic [ADDR_W-1:0] step, wrapMask, incrNext, wrapNext, nextAddr, wordIdx;
  logic              inRange, endMismatch;
  assign step     = ADDR_W'(1) << sizeReg;
  assign wrapMask = ((ADDR_W'(lenReg) + ADDR_W'(1)) << sizeReg) - ADDR_W'(1);
  assign incrNext = (curAddr & ~(step - ADDR_W'(1))) + step;
  assign wrapNext = (curAddr & ~wrapMask) | ((curAddr + step) & wrapMask);

  always_comb begin
    unique case (burstReg)
      BURST_INCR: nextAddr = incrNext;
      BURST_WRAP: nextAddr = wrapNext;
      default:    nextAddr = curAddr;
    endcase
  end

  assign wordIdx     = curAddr >> BYTE_SHIFT;
  assign inRange     = wordIdx < ADDR_W'(DEPTH);
  assign endMismatch = wLast != (beatCnt == {1'b0, lenReg});

  // Per-lane write mask
  logic [DATA_W-1:0] laneMask;
  for (genvar l = 0; l < LANES; l++) begin : gLane
    assign laneMask[8*l +: 8] = {8{wStrb[l]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg    <= '0;
      curAddr  <= '0;
      lenReg   <= '0;
      sizeReg  <= '0;
      burstReg <= '0;
      beatCnt  <= '0;
      reqBad   <= 1'b0;
      errFlag  <= 1'b0;
    end else if (ctl.capture) begin
      idReg    <= awId;
      curAddr  <= awAddr;
      lenReg   <= awLen;
      sizeReg  <= awSize;
      burstReg <= awBurst;
      beatCnt  <= '0;
      reqBad   <= reqBadIn;
      errFlag  <= reqBadIn;
    end else if (ctl.beat) begin
      curAddr  <= nextAddr;
      beatCnt  <= beatCnt + 9'd1;
      errFlag  <= errFlag | !inRange | endMismatch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.beat && inRange && !reqBad) begin
      mem[wordIdx[IDX_W-1:0]] <= (mem[wordIdx[IDX_W-1:0]] & ~laneMask) | (wData & laneMask);
    end
  end

  assign bId      = idReg;
  assign bResp    = errFlag ? RESP_SLVERR : RESP_OKAY;
  assign peekData = mem[peekIdx];

  // R8: a beat outside the array marks the burst as failed
  assert_oob_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.beat && !inRange) |=> (bResp == RESP_SLVERR));

  // R9: a last marker on the wrong beat marks the burst as failed
  assert_bad_end_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.beat && endMismatch) |=> (bResp == RESP_SLVERR));

  // R10: an illegal request is failed from its first cycle
  assert_bad_req_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && reqBadIn) |=> (bResp == RESP_SLVERR));
endmodule

// File: rtl/axi_burst_write_target.sv
`timescale 1ns/1ps
module axi_burst_write_target
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   awId,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [7:0]        awLen,
  input  logic [2:0]        awSize,
  input  logic [1:0]        awBurst,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic [LANES-1:0]  wStrb,
  input  logic              wLast,
  input  logic              wValid,
  output logic              wReady,
  output logic [ID_W-1:0]   bId,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [DATA_W-1:0] peekData
);
  wbtCtl_s ctl;

  wbt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .awValid(awValid), .wValid(wValid), .wLast(wLast),
    .bReady(bReady), .awReady(awReady), .wReady(wReady), .bValid(bValid), .ctl(ctl)
  );

  wbt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .awId(awId), .awAddr(awAddr), .awLen(awLen),
    .awSize(awSize), .awBurst(awBurst), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .peekIdx(peekIdx), .bId(bId), .bResp(bResp), .peekData(peekData)
  );

  // R6: a pending response holds with stable content
  assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> (bValid && $stable(bId) && $stable(bResp)));

  // R7: the response carries the ID latched with the address
  assert_resp_id_R7: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && awReady) |=> (bId == $past(awId)));
endmodule

// File: tb/axi_burst_write_target_tb.sv
`timescale 1ns/1ps
module axi_burst_write_target_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  awId = '0;
  logic [11:0] awAddr = '0;
  logic [7:0]  awLen = '0;
  logic [2:0]  awSize = '0;
  logic [1:0]  awBurst = '0;
  logic        awValid = 1'b0;
  logic        awReady;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = '0;
  logic        wLast = 1'b0;
  logic        wValid = 1'b0;
  logic        wReady;
  logic [3:0]  bId;
  logic [1:0]  bResp;
  logic        bValid;
  logic        bReady = 1'b0;
  logic [5:0]  peekIdx = '0;
  logic [31:0] peekData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] model [DEPTH];

  always #5 clk = ~clk;

  axi_burst_write_target u_dut (
    .clk(clk), .rstN(rstN), .awId(awId), .awAddr(awAddr), .awLen(awLen), .awSize(awSize),
    .awBurst(awBurst), .awValid(awValid), .awReady(awReady), .wData(wData), .wStrb(wStrb),
    .wLast(wLast), .wValid(wValid), .wReady(wReady), .bId(bId), .bResp(bResp),
    .bValid(bValid), .bReady(bReady), .peekIdx(peekIdx), .peekData(peekData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected byte address of beat n, written from the burst rules
  function automatic int beatAddr(input int start, input int size, input int burst,
                                  input int len, input int n);
    int stepB = 1 << size;
    int total = (len + 1) * stepB;
    int base;
    if (burst == 0 || n == 0) return start;
    if (burst == 1) return (start / stepB) * stepB + n * stepB;
    base = (start / total) * total;
    return base + ((start - base + n * stepB) % total);
  endfunction

  task automatic checkMem(input string req);
    int bad = 0;
    int firstIdx = 0;
    logic [31:0] a = '0, e = '0;
    for (int i = 0; i < DEPTH; i++) begin
      peekIdx = 6'(i);
      #1;
      if (peekData !== model[i] && bad == 0) begin
        firstIdx = i; a = peekData; e = model[i];
      end
      if (peekData !== model[i]) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: word %0d actual 0x%0h expected 0x%0h", req, firstIdx, a, e);
    end
    @(negedge clk);
  endtask

  // One burst: lastPos is the beat index that carries wLast
  task automatic runBurst(input logic [3:0] id, input int start, input int size,
                          input int burst, input int len, input int lastPos,
                          input string req);
    bit bad, err, got;
    int a, holds;
    logic [1:0] expResp;
    bad = (size > 2) || (burst == 3) ||
          (burst == 2 && !(len == 1 || len == 3 || len == 7 || len == 15));
    err = bad || (lastPos != len);
    @(negedge clk);
    check({"R12 idle wReady ", req}, {31'b0, wReady}, 32'd0);
    check({"R1 idle awReady ", req}, {31'b0, awReady}, 32'd1);
    repeat ($urandom % 3) @(negedge clk);
    awId = id; awAddr = 12'(start); awLen = 8'(len); awSize = 3'(size);
    awBurst = 2'(burst); awValid = 1'b1;
    got = 0;
    while (!got) begin #1; got = awReady; @(negedge clk); end
    awValid = 1'b0;
    check({"R1 awReady low in burst ", req}, {31'b0, awReady}, 32'd0);
    for (int n = 0; n <= lastPos; n++) begin
      repeat ($urandom % 2) @(negedge clk);
      wData = $urandom; wStrb = 4'($urandom); wLast = (n == lastPos); wValid = 1'b1;
      got = 0;
      while (!got) begin #1; got = wReady; @(negedge clk); end
      wValid = 1'b0; wLast = 1'b0;
      a = beatAddr(start, size, burst, len, n);
      if ((a >> 2) >= DEPTH) err = 1;
      else if (!bad)
        for (int k = 0; k < 4; k++)
          if (wStrb[k]) model[a >> 2][8*k +: 8] = wData[8*k +: 8];
    end
    expResp = err ? 2'b10 : 2'b00;
    check({"R6 bValid after last beat ", req}, {31'b0, bValid}, 32'd1);
    check({"R12 wReady low while responding ", req}, {31'b0, wReady}, 32'd0);
    holds = $urandom % 4;
    for (int h = 0; h < holds; h++) begin
      @(negedge clk);
      check({"R6 response held ", req}, {29'b0, bValid, bResp}, {29'b0, 1'b1, expResp});
    end
    check({"R7 bId ", req}, {28'b0, bId}, {28'b0, id});
    check({"bResp ", req}, {30'b0, bResp}, {30'b0, expResp});
    bReady = 1'b1;
    @(negedge clk);
    bReady = 1'b0;
    check({"R6 single response ", req}, {31'b0, bValid}, 32'd0);
    check({"R1 awReady reopens ", req}, {31'b0, awReady}, 32'd1);
    checkMem({"R2 memory ", req});
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset awReady", {31'b0, awReady}, 32'd1);
    check("R11 reset bValid", {31'b0, bValid}, 32'd0);
    check("R11 reset wReady", {31'b0, wReady}, 32'd0);
    checkMem("R11 reset clears array");

    runBurst(4'h1, 'h000, 2, 1, 3, 3, "R3 incr 4 beats");
    runBurst(4'h2, 'h021, 2, 1, 2, 2, "R3 incr unaligned start");
    runBurst(4'h3, 'h044, 0, 0, 5, 5, "R4 fixed narrow");
    runBurst(4'h4, 'h038, 2, 2, 3, 3, "R5 wrap mid-window");
    runBurst(4'h5, 'h0A6, 1, 2, 7, 7, "R5 wrap halfwords");
    runBurst(4'h6, 'h080, 2, 2, 2, 2, "R5 wrap illegal length");
    runBurst(4'h7, 'h080, 3, 1, 1, 1, "R10 size too wide");
    runBurst(4'h8, 'h080, 2, 3, 1, 1, "R10 reserved burst code");
    runBurst(4'h9, 'h0F8, 2, 1, 3, 3, "R8 straddles array top");
    runBurst(4'hA, 'h100, 2, 0, 0, 0, "R8 fully outside");
    runBurst(4'hB, 'h010, 2, 1, 3, 1, "R9 early last");
    runBurst(4'hC, 'h030, 2, 1, 1, 3, "R9 late last");
    runBurst(4'hD, 'h060, 2, 1, 0, 0, "R3 single beat");
    runBurst(4'hE, 'h010, 0, 0, 255, 255, "R4 fixed 256 beats");

    for (int t = 0; t < 40; t++) begin
      int size = $urandom % 3;
      int burst = $urandom % 3;
      int len, lastPos, start;
      if (burst == 2) begin
        case ($urandom % 4)
          0: len = 1; 1: len = 3; 2: len = 7; default: len = 15;
        endcase
      end else len = $urandom % 8;
      start = ($urandom % 320) & ~((1 << size) - 1);
      lastPos = len;
      if ($urandom % 8 == 0) lastPos = (len > 0) ? len - 1 : len + 1;
      runBurst(4'($urandom), start, size, burst, len, lastPos, "R2 random");
    end

    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    @(negedge clk);
    check("R11 re-reset awReady", {31'b0, awReady}, 32'd1);
    check("R11 re-reset bValid", {31'b0, bValid}, 32'd0);
    checkMem("R11 re-reset clears array");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule